// File: doc/BRIEF.md
# H-Bridge Slow-Decay PWM Driver

This block produces the four active-high gate enables of a full H-bridge that feeds a brushed DC motor. Side U has a high switch and a low switch, and so does side V. The inputs are a direction bit, an enable, a duty value, a PWM period and two dead-time counts. A free-running counter divides time into PWM periods. In each direction, one low switch stays on for the whole period. The opposite half-bridge switches its high and low switches in complement, and dead time separates every changeover. During the off-time, motor current recirculates through both low switches. This is slow decay.

Duty, period and direction are sampled only at period boundaries. A direction change first turns off all four switches for one full dead-time interval. Dropping the enable turns off every gate in the same cycle. Raising the enable again starts a fresh period from count zero.

Top module: `hbridge_slowdecay_drv`

## Requirements
- R1: While `enable` is low, all four gate outputs are low. This includes the cycle in which `enable` falls, and the reset state.
- R2: With `dirFwd`=1, `gateVl` is on and `gateVh` is off. Side U carries the PWM: `gateUh` is the high switch and `gateUl` is its complement.
- R3: With `dirFwd`=0, `gateUl` is on and `gateUh` is off. Side V carries the PWM: `gateVh` is the high switch and `gateVl` is its complement.
- R4: Each PWM period lasts `period` clock ticks (a value of 0 acts as 1). The raw PWM level is high for the first min(`duty`,`period`) ticks of the period.
- R5: The high switch of the PWM side turns on only after the raw PWM level has been high for `leadDelay`+1 consecutive ticks. A count of 0 gives no delay.
- R6: The low switch of the PWM side turns on only after the raw PWM level has been low for `trailDelay`+1 consecutive ticks. A count of 0 gives no delay.
- R7: `gateUh` and `gateUl` are never high together, and `gateVh` and `gateVl` are never high together.
- R8: A change of `duty` or `period` while running takes effect at the first period boundary after the change.
- R9: A change of `dirFwd` while running is acted on at the next period boundary. For max(`leadDelay`,`trailDelay`,1) cycles all four gates are low. The new direction then starts a fresh period.
- R10: If `duty` is 0, the PWM high switch stays off for the whole period and its complement stays on. If `duty` is at least `period`, the high switch stays on for the whole period and its complement stays off.
- R11: When `enable` rises, the first enabled cycle is count 0 of a new period. That period uses the duty, period and direction that were present while the block was disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Bridge enable. Low forces all gates off |
| dirFwd | input | 1 | 1: current flows from U to V. 0: current flows from V to U |
| duty | input | CNT_W | On-time in ticks |
| period | input | CNT_W | PWM period in ticks |
| leadDelay | input | DT_W | Turn-on delay of the PWM high switch |
| trailDelay | input | DT_W | Turn-on delay of the PWM low switch |
| gateUh | output | 1 | U high switch enable |
| gateUl | output | 1 | U low switch enable |
| gateVh | output | 1 | V high switch enable |
| gateVl | output | 1 | V low switch enable |

## Verification
The gates are combinational functions of registered state and `enable`. A drop of `enable` therefore shows in the same cycle. An enable that rises during a cycle makes that cycle count 0. A duty, period or direction change is due at the first boundary cycle after it, and a direction change adds the blanking cycles before the new direction starts. The bench drives inputs on the falling edge and samples 2 ns later, inside the same cycle. Each expected gate vector is computed from the cycle index since enable. The raw PWM level at cycle t is (t mod period) < duty. The delay rule looks back `leadDelay` or `trailDelay` cycles, and cycles before enable count as low.

// File: rtl/hb_pkg.sv
package hb_pkg;

  typedef enum logic {
    ST_RUN   = 1'b0,
    ST_BLANK = 1'b1
  } hbState_e;

  // Strobes handed from control to datapath each cycle
  typedef struct packed {
    logic pwmOn;   // raw PWM level for this tick
    logic blank;   // force every gate off
    logic dirFwd;  // latched steering direction
  } hbStrobes_t;

endpackage

// File: rtl/hb_ctrl.sv
module hb_ctrl
  import hb_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DT_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             dirIn,
  input  logic [CNT_W-1:0] dutyIn,
  input  logic [CNT_W-1:0] periodIn,
  input  logic [DT_W-1:0]  leadDelay,
  input  logic [DT_W-1:0]  trailDelay,
  output hbStrobes_t       strobes
);

  hbState_e         stateQ;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] dutyQ;
  logic [CNT_W-1:0] periodQ;
  logic             dirQ;
  logic [DT_W-1:0]  blankCntQ;

  logic [CNT_W-1:0] lastIdx;
  logic [DT_W-1:0]  longest;
  logic [DT_W-1:0]  blankLast;
  logic             atWrap;

  always_comb begin
    lastIdx = (periodQ == '0) ? '0 : periodQ - 1'b1;
    atWrap  = (cntQ >= lastIdx);
  end

  // The blanking interval covers the longer dead time, with a minimum of one tick
  always_comb begin
    longest = (leadDelay > trailDelay) ? leadDelay : trailDelay;
    if (longest == '0) longest = {{(DT_W-1){1'b0}}, 1'b1};
    blankLast = longest - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stateQ    <= ST_RUN;
      cntQ      <= '0;
      dutyQ     <= '0;
      periodQ   <= '0;
      dirQ      <= 1'b1;
      blankCntQ <= '0;
    end else if (!enable) begin
      stateQ    <= ST_RUN;
      cntQ      <= '0;
      blankCntQ <= '0;
      dutyQ     <= dutyIn;
      periodQ   <= periodIn;
      dirQ      <= dirIn;
    end else begin
      unique case (stateQ)
        ST_RUN: begin
          if (atWrap) begin
            if (dirIn != dirQ) begin
              stateQ    <= ST_BLANK;
              blankCntQ <= '0;
            end else begin
              cntQ    <= '0;
              dutyQ   <= dutyIn;
              periodQ <= periodIn;
            end
          end else begin
            cntQ <= cntQ + 1'b1;
          end
        end
        ST_BLANK: begin
          if (blankCntQ >= blankLast) begin
            stateQ  <= ST_RUN;
            cntQ    <= '0;
            dutyQ   <= dutyIn;
            periodQ <= periodIn;
            dirQ    <= dirIn;
          end else begin
            blankCntQ <= blankCntQ + 1'b1;
          end
        end
        default: stateQ <= ST_RUN;
      endcase
    end
  end

  always_comb begin
    strobes.pwmOn  = (cntQ < dutyQ);
    strobes.blank  = !enable || (stateQ == ST_BLANK);
    strobes.dirFwd = dirQ;
  end

endmodule

// File: rtl/hb_datapath.sv
module hb_datapath
  import hb_pkg::*;
#(
  parameter int DT_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  hbStrobes_t      strobes,
  input  logic [DT_W-1:0] leadDelay,
  input  logic [DT_W-1:0] trailDelay,
  output logic            uh,
  output logic            ul,
  output logic            vh,
  output logic            vl
);

  localparam int AGE_W = DT_W + 1;
  localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

  logic             levelNow;
  logic             levelPrevQ;
  logic [AGE_W-1:0] ageQ;
  logic [AGE_W-1:0] ageNow;
  logic             hiSw;
  logic             loSw;
  logic             rawUh, rawUl, rawVh, rawVl;

  assign levelNow = strobes.pwmOn && !strobes.blank;

  // ageNow: how many earlier consecutive ticks had the same level (saturating)
  always_comb begin
    if (levelNow == levelPrevQ)
      ageNow = (ageQ == AGE_MAX) ? ageQ : ageQ + 1'b1;
    else
      ageNow = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      levelPrevQ <= 1'b0;
      ageQ       <= AGE_MAX;
    end else begin
      levelPrevQ <= levelNow;
      ageQ       <= ageNow;
    end
  end

  always_comb begin
    hiSw = levelNow  && (ageNow >= {1'b0, leadDelay});
    loSw = !levelNow && (ageNow >= {1'b0, trailDelay});
  end

  // Steering: the held low switch sits on the side opposite the PWM
  always_comb begin
    if (strobes.dirFwd) begin
      rawUh = hiSw; rawUl = loSw; rawVh = 1'b0; rawVl = 1'b1;
    end else begin
      rawUh = 1'b0; rawUl = 1'b1; rawVh = hiSw; rawVl = loSw;
    end
  end

  // Final gating with blanking, plus a shoot-through guard per half-bridge
  always_comb begin
    uh = rawUh && !rawUl && !strobes.blank;
    ul = rawUl && !rawUh && !strobes.blank;
    vh = rawVh && !rawVl && !strobes.blank;
    vl = rawVl && !rawVh && !strobes.blank;
  end

endmodule

// File: rtl/hbridge_slowdecay_drv.sv
module hbridge_slowdecay_drv
  import hb_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DT_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             dirFwd,
  input  logic [CNT_W-1:0] duty,
  input  logic [CNT_W-1:0] period,
  input  logic [DT_W-1:0]  leadDelay,
  input  logic [DT_W-1:0]  trailDelay,
  output logic             gateUh,
  output logic             gateUl,
  output logic             gateVh,
  output logic             gateVl
);

  hbStrobes_t strobes;

  hb_ctrl #(.CNT_W(CNT_W), .DT_W(DT_W)) uCtrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .dirIn      (dirFwd),
    .dutyIn     (duty),
    .periodIn   (period),
    .leadDelay  (leadDelay),
    .trailDelay (trailDelay),
    .strobes    (strobes)
  );

  hb_datapath #(.DT_W(DT_W)) uPath (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobes    (strobes),
    .leadDelay  (leadDelay),
    .trailDelay (trailDelay),
    .uh         (gateUh),
    .ul         (gateUl),
    .vh         (gateVh),
    .vl         (gateVl)
  );

endmodule

// File: rtl/hbridge_slowdecay_chk.sv
module hbridge_slowdecay_chk #(
  parameter int DT_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            enable,
  input logic [DT_W-1:0] leadDelay,
  input logic [DT_W-1:0] trailDelay,
  input logic            gateUh,
  input logic            gateUl,
  input logic            gateVh,
  input logic            gateVl
);

  assert_off_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !(gateUh || gateUl || gateVh || gateVl));

  assert_no_shoot_u_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(gateUh && gateUl));

  assert_no_shoot_v_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(gateVh && gateVl));

  assert_legal_fwd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    gateUh |-> (gateVl && !gateVh));

  assert_legal_rev_R3: assert property (@(posedge clk) disable iff (!rst_n)
    gateVh |-> (gateUl && !gateUh));

  assert_lead_gap_u_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (leadDelay != '0 && $rose(gateUh)) |-> !$past(gateUl));

  assert_lead_gap_v_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (leadDelay != '0 && $rose(gateVh)) |-> !$past(gateVl));

  assert_trail_gap_u_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (trailDelay != '0 && $rose(gateUl)) |-> !$past(gateUh));

  assert_trail_gap_v_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (trailDelay != '0 && $rose(gateVl)) |-> !$past(gateVh));

endmodule

bind hbridge_slowdecay_drv hbridge_slowdecay_chk #(.DT_W(DT_W)) uChk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .leadDelay  (leadDelay),
  .trailDelay (trailDelay),
  .gateUh     (gateUh),
  .gateUl     (gateUl),
  .gateVh     (gateVh),
  .gateVl     (gateVl)
);

// File: tb/tb_hbridge_slowdecay_drv.sv
`timescale 1ns/1ps
module tb_hbridge_slowdecay_drv;

  localparam int CNT_W = 8;
  localparam int DT_W  = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic enable;
  logic dirFwd;
  logic [CNT_W-1:0] duty;
  logic [CNT_W-1:0] period;
  logic [DT_W-1:0]  leadDelay;
  logic [DT_W-1:0]  trailDelay;
  logic gateUh, gateUl, gateVh, gateVl;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  // Piecewise model of the raw PWM level: segment 1 before mTB, segment 2 from it
  int mP1, mD1, mP2, mD2, mTB;

  always #4 clk = ~clk;  // 125 MHz

  hbridge_slowdecay_drv #(.CNT_W(CNT_W), .DT_W(DT_W)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .dirFwd(dirFwd),
    .duty(duty), .period(period), .leadDelay(leadDelay), .trailDelay(trailDelay),
    .gateUh(gateUh), .gateUl(gateUl), .gateVh(gateVh), .gateVl(gateVl)
  );

  function automatic bit sHist(int t);
    if (t < 0) return 1'b0;
    if (t < mTB) return (t % mP1) < mD1;
    return ((t - mTB) % mP2) < mD2;
  endfunction

  // Expected {uh,ul,vh,vl} at cycle t after enable
  function automatic logic [3:0] expGates(int t, bit fwd, int L, int T);
    bit hi = 1'b1;
    bit lo = 1'b1;
    for (int k = 0; k <= L; k++) if (!sHist(t - k)) hi = 1'b0;
    for (int k = 0; k <= T; k++) if (sHist(t - k)) lo = 1'b0;
    return fwd ? {hi, lo, 1'b0, 1'b1} : {1'b0, 1'b1, hi, lo};
  endfunction

  task automatic checkGates(logic [3:0] exp, string tag, int t);
    logic [3:0] act;
    act = {gateUh, gateUl, gateVh, gateVl};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: gates(uh,ul,vh,vl)=%b expected %b", tag, t, act, exp);
    end
  endtask

  // Disable (checking the same-cycle turn-off), load the inputs, hold disabled
  task automatic idleLoad(bit fwd, int P, int D, int L, int T);
    @(negedge clk);
    enable = 1'b0;
    #2 checkGates(4'b0000, "R1 same-cycle disable", -1);
    dirFwd = fwd; period = P[CNT_W-1:0]; duty = D[CNT_W-1:0];
    leadDelay = L[DT_W-1:0]; trailDelay = T[DT_W-1:0];
    repeat (20) @(negedge clk);
  endtask

  task automatic sweepRun(bit fwd, int P, int D, int L, int T);
    string tag;
    idleLoad(fwd, P, D, L, T);
    mP1 = P; mD1 = D; mTB = 1 << 30; mP2 = 1; mD2 = 0;
    if (D == 0 || D >= P) tag = "R10";
    else tag = fwd ? "R2 R4 R5 R6 R7 R11" : "R3 R4 R5 R6 R7 R11";
    for (int t = 0; t < 3 * P + 20; t++) begin
      @(negedge clk);
      if (t == 0) enable = 1'b1;
      #2 checkGates(expGates(t, fwd, L, T), tag, t);
    end
  endtask

  initial begin
    rst_n = 1'b0; enable = 1'b0; dirFwd = 1'b1; duty = '0; period = 8'd4;
    leadDelay = '0; trailDelay = '0;
    repeat (3) @(negedge clk);
    #2 checkGates(4'b0000, "R1 reset state", -1);
    rst_n = 1'b1;
    @(negedge clk);
    #2 checkGates(4'b0000, "R1 idle after reset", -1);

    // Near-exhaustive sweep over a small configuration
    begin
      int pl [5] = '{1, 2, 3, 5, 8};
      int ll [3] = '{0, 1, 2};
      int tl [3] = '{0, 2, 3};
      for (int dir = 0; dir < 2; dir++)
        for (int pi = 0; pi < 5; pi++)
          for (int d = 0; d <= pl[pi] + 1; d++)
            for (int li = 0; li < 3; li++)
              for (int ti = 0; ti < 3; ti++)
                sweepRun(dir[0], pl[pi], d, ll[li], tl[ti]);
    end

    // R8: duty and period change mid-period take effect at the next boundary
    idleLoad(1'b1, 4, 1, 1, 1);
    mP1 = 4; mD1 = 1; mP2 = 6; mD2 = 4; mTB = 8;
    for (int t = 0; t < 30; t++) begin
      @(negedge clk);
      if (t == 0) enable = 1'b1;
      if (t == 5) begin period = 8'd6; duty = 8'd4; end
      #2 checkGates(expGates(t, 1'b1, 1, 1), "R8", t);
    end

    // R9: direction change with blanking of max(lead,trail,1) cycles
    for (int c = 0; c < 2; c++) begin
      int L = (c == 0) ? 1 : 0;
      int T = (c == 0) ? 2 : 0;
      int B = (c == 0) ? 2 : 1;
      int tB = 10;
      idleLoad(1'b1, 5, 3, L, T);
      mP1 = 5; mD1 = 3; mP2 = 1; mD2 = 0; mTB = 1 << 30;
      for (int t = 0; t < 35; t++) begin
        logic [3:0] e;
        @(negedge clk);
        if (t == 0) enable = 1'b1;
        if (t == 7) dirFwd = 1'b0;
        if (t < tB) e = expGates(t, 1'b1, L, T);
        else if (t < tB + B) e = 4'b0000;
        else e = expGates(t - tB - B, 1'b0, L, T);
        #2 checkGates(e, "R9", t);
      end
    end

    idleLoad(1'b1, 4, 2, 0, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: run did not end, cycles=%0d expected below 190000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule